// File: doc/BRIEF.md
# Address Window Guard

This block sits between a DMA engine's address generator and the system interconnect. Every outgoing transaction address is compared against up to eight programmable decode windows. Each window has a base, a size mask with 64 KB granularity and an enable bit. The window that matches supplies a 4-bit target ID, an 8-bit attribute byte and, for the first few windows only, the upper 32 bits of a 64-bit outgoing address. Every request carries a channel number, and each channel has its own 2-bit permission code for every window. A request therefore resolves to exactly one of four outcomes: granted, address miss, access violation or write-protect violation. The outcome appears one clock cycle after the request.

Errors are recorded in two places. Each channel has a sticky cause field that software clears by writing 1s. An error logger holds the address and the kind of the first error. The logger is a two-state machine. In LOCK_OPEN it waits for an error. The transition *capture* takes it to LOCK_HELD and stores the failing address and an error select code. In LOCK_HELD it ignores further errors. The transition *release* takes it back to LOCK_OPEN, and it fires on any register write to the error select register.

Software programs the block through a word-indexed register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `addr_window_guard`

## Requirements
- R1: After reset, every register reads 0, no window is enabled, `rsp_valid` and all outcome flags are low, and the error logger is in LOCK_OPEN.
- R2: Register map by word index. Index 0..7 is window base w: bits 31:16 base, 15:8 attribute, 3:0 target, other bits read 0. Index 8..15 is window size w: bits 31:16 hold the mask, which is size/64 KB − 1, and bits 15:0 read 0. Index 16 holds the window enables, bit w for window w. Index 20..23 is channel c permissions, field w at bits 2w+1:2w. Index 24..27 is high remap r. Index 28 is cause. Index 29 is error address. Index 30 is error select.
- R3: Window w hits when it is enabled and (addr[31:16] & ~mask) equals base[31:16].
- R4: When several windows hit, the lowest-numbered window is used.
- R5: One cycle after an accepted request, `rsp_valid` is high and `rsp_win`, `rsp_target` and `rsp_attr` give the matched window's index, target and attribute.
- R6: `rsp_addr[31:0]` equals the request address. `rsp_addr[63:32]` is remap register w for windows 0..3 and 0 for windows 4 and above.
- R7: A request that hits no enabled window gives `rsp_miss`, with window, target, attribute and `rsp_addr[63:32]` all 0.
- R8: The permission code selects the outcome. Code 0 (none) and code 2 (reserved) give `rsp_acc_viol`. Code 1 (read only) gives `rsp_wr_viol` on writes and a grant on reads. Code 3 gives a grant. A blocked response still reports the matched window, target and attribute. Codes are taken from the requesting channel's register.
- R9: Each valid response raises exactly one of `rsp_grant`, `rsp_miss`, `rsp_acc_viol` and `rsp_wr_viol`.
- R10: In LOCK_OPEN, an error takes the *capture* transition. It stores the request address and an error select value of {channel, kind}, with kind 1 = miss, 2 = access, 3 = write. Reading index 30 returns the lock state in bit 31 and the select value in bits 4:0.
- R11: In LOCK_HELD, later errors leave the error address and select unchanged. Any write to index 30 takes the *release* transition to LOCK_OPEN and keeps the stored values. A release and an error in the same cycle give release.
- R12: Every error sets cause bit 8·channel + kind. Writing 1s to index 28 clears those bits. A bit set in the same cycle as its clear stays set.
- R13: A cycle with `req_valid` low produces no response and changes neither the cause bits nor the error log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register word index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a write |
| req_chan | input | 2 | Requesting channel |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_miss | output | 1 | No window matched |
| rsp_acc_viol | output | 1 | Access blocked by permission code |
| rsp_wr_viol | output | 1 | Write to read-only window |
| rsp_win | output | 3 | Matched window index |
| rsp_target | output | 4 | Target ID |
| rsp_attr | output | 8 | Attribute byte |
| rsp_addr | output | 64 | Outgoing address, upper half remapped |

## Verification
The bench builds the block with its defaults: eight windows, four channels and four remap registers. This puts the boundary between remapped and unremapped windows (3 and 4) within reach, along with the highest channel's slice of the cause register. Random configurations use masks of up to 64 windows of 64 KB. Bases and addresses are drawn from the same 256 upper-address values, so hits, overlaps, misses and all four permission codes occur often. Directed cases cover the window edges, overlap priority, a write-only release and the logger's lock and release order.

// File: rtl/awg_pkg.sv
package awg_pkg;

    localparam int IDX_W       = 5;
    localparam int REG_BASE0   = 0;
    localparam int REG_SIZE0   = 8;
    localparam int REG_ENABLE  = 16;
    localparam int REG_PROT0   = 20;
    localparam int REG_REMAP0  = 24;
    localparam int REG_CAUSE   = 28;
    localparam int REG_ERRADDR = 29;
    localparam int REG_ERRSEL  = 30;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RSVD = 2'd2,
        PERM_FULL = 2'd3
    } perm_e;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_MISS   = 3'd1,
        KIND_ACCESS = 3'd2,
        KIND_WRITE  = 3'd3
    } err_kind_e;

    typedef enum logic {
        LOCK_OPEN = 1'b0,
        LOCK_HELD = 1'b1
    } lock_state_e;

endpackage

// File: rtl/awg_cfg_regs.sv
module awg_cfg_regs
    import awg_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_CH    = 4,
    parameter int NUM_REMAP = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   idx,
    input  logic [31:0]                        wr_data,
    output logic [31:0]                        rd_data,
    output logic [NUM_WIN-1:0][15:0]           base_hi,
    output logic [NUM_WIN-1:0][15:0]           mask_hi,
    output logic [NUM_WIN-1:0][3:0]            tgt,
    output logic [NUM_WIN-1:0][7:0]            attr,
    output logic [NUM_WIN-1:0]                 win_en,
    output logic [NUM_CH-1:0][2*NUM_WIN-1:0]   prot,
    output logic [NUM_REMAP-1:0][31:0]         remap
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            mask_hi <= '0;
            tgt     <= '0;
            attr    <= '0;
            win_en  <= '0;
            prot    <= '0;
            remap   <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (idx == IDX_W'(REG_BASE0 + w)) begin
                    base_hi[w] <= wr_data[31:16];
                    attr[w]    <= wr_data[15:8];
                    tgt[w]     <= wr_data[3:0];
                end
                if (idx == IDX_W'(REG_SIZE0 + w)) begin
                    mask_hi[w] <= wr_data[31:16];
                end
            end
            if (idx == IDX_W'(REG_ENABLE)) begin
                win_en <= wr_data[NUM_WIN-1:0];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (idx == IDX_W'(REG_PROT0 + c)) begin
                    prot[c] <= wr_data[2*NUM_WIN-1:0];
                end
            end
            for (int r = 0; r < NUM_REMAP; r++) begin
                if (idx == IDX_W'(REG_REMAP0 + r)) begin
                    remap[r] <= wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (idx == IDX_W'(REG_BASE0 + w)) begin
                rd_data = {base_hi[w], attr[w], 4'b0000, tgt[w]};
            end
            if (idx == IDX_W'(REG_SIZE0 + w)) begin
                rd_data = {mask_hi[w], 16'h0000};
            end
        end
        if (idx == IDX_W'(REG_ENABLE)) begin
            rd_data = 32'(win_en);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (idx == IDX_W'(REG_PROT0 + c)) begin
                rd_data = 32'(prot[c]);
            end
        end
        for (int r = 0; r < NUM_REMAP; r++) begin
            if (idx == IDX_W'(REG_REMAP0 + r)) begin
                rd_data = remap[r];
            end
        end
    end

endmodule

// File: rtl/awg_window_match.sv
module awg_window_match #(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input  logic [15:0]                 addr_hi,
    input  logic [NUM_WIN-1:0][15:0]    base_hi,
    input  logic [NUM_WIN-1:0][15:0]    mask_hi,
    input  logic [NUM_WIN-1:0]          win_en,
    output logic                        hit,
    output logic [WIN_W-1:0]            win_idx
);

    logic [NUM_WIN-1:0] raw_hit;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign raw_hit[w] = win_en[w] && ((addr_hi & ~mask_hi[w]) == base_hi[w]);
    end

    // Scan from the top so that the lowest matching window is the last one written.
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (raw_hit[w]) begin
                hit     = 1'b1;
                win_idx = WIN_W'(w);
            end
        end
    end

    always_comb begin
        if (hit) begin
            assert_lowest_wins_R4: assert (raw_hit[win_idx] &&
                ((raw_hit & ((NUM_WIN'(1) << win_idx) - NUM_WIN'(1))) == '0));
        end
    end

endmodule

// File: rtl/awg_perm_check.sv
module awg_perm_check
    import awg_pkg::*;
(
    input  logic  hit,
    input  perm_e code,
    input  logic  is_write,
    output logic  grant,
    output logic  acc_viol,
    output logic  wr_viol
);

    always_comb begin
        grant    = 1'b0;
        acc_viol = 1'b0;
        wr_viol  = 1'b0;
        unique case (code)
            PERM_FULL: grant = hit;
            PERM_RO: begin
                if (is_write) wr_viol = hit;
                else          grant   = hit;
            end
            PERM_NONE, PERM_RSVD: acc_viol = hit;
        endcase
    end

    always_comb begin
        assert_single_viol_R8: assert (!(acc_viol && wr_viol) && !(grant && (acc_viol || wr_viol)));
    end

endmodule

// File: rtl/awg_err_log.sv
module awg_err_log
    import awg_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int SEL_W = CH_W + 3,
    localparam int CAU_W = 8 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  err_kind_e         ev_kind,
    input  logic [CH_W-1:0]   ev_chan,
    input  logic [31:0]       ev_addr,
    input  logic              release_req,
    input  logic              cause_wr,
    input  logic [CAU_W-1:0]  cause_clr,
    output logic [31:0]       err_addr,
    output logic [SEL_W-1:0]  err_sel,
    output logic [CAU_W-1:0]  cause,
    output logic              locked
);

    lock_state_e state_q, state_d;
    logic        capture;
    logic [CAU_W-1:0] set_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LOCK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            LOCK_OPEN: begin
                if (ev_valid && !release_req) begin
                    capture = 1'b1;
                    state_d = LOCK_HELD;
                end
            end
            LOCK_HELD: begin
                if (release_req) state_d = LOCK_OPEN;
            end
        endcase
    end

    assign locked = (state_q == LOCK_HELD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_addr <= '0;
            err_sel  <= '0;
        end else if (capture) begin
            err_addr <= ev_addr;
            err_sel  <= {ev_chan, ev_kind};
        end
    end

    always_comb begin
        set_vec = '0;
        if (ev_valid) begin
            set_vec[8 * int'(ev_chan) + int'(ev_kind)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & ~(cause_wr ? cause_clr : '0)) | set_vec;
    end

    assert_lock_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !release_req) |=> ($stable(err_addr) && $stable(err_sel)));

    assert_capture_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (err_sel[2:0] != 3'd0 && err_sel[2:0] < 3'd4));

    assert_cause_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> (cause != '0));

endmodule

// File: rtl/addr_window_guard.sv
module addr_window_guard
    import awg_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_CH    = 4,
    parameter int NUM_REMAP = 4,
    localparam int WIN_W    = $clog2(NUM_WIN),
    localparam int CH_W     = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [4:0]         reg_idx,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CH_W-1:0]    req_chan,
    input  logic [31:0]        req_addr,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic               rsp_miss,
    output logic               rsp_acc_viol,
    output logic               rsp_wr_viol,
    output logic [WIN_W-1:0]   rsp_win,
    output logic [3:0]         rsp_target,
    output logic [7:0]         rsp_attr,
    output logic [63:0]        rsp_addr
);

    localparam int SEL_W = CH_W + 3;
    localparam int CAU_W = 8 * NUM_CH;

    logic [31:0]                      cfg_rdata;
    logic [NUM_WIN-1:0][15:0]         base_hi, mask_hi;
    logic [NUM_WIN-1:0][3:0]          tgt;
    logic [NUM_WIN-1:0][7:0]          attr;
    logic [NUM_WIN-1:0]               win_en;
    logic [NUM_CH-1:0][2*NUM_WIN-1:0] prot;
    logic [NUM_REMAP-1:0][31:0]       remap;
    logic [NUM_WIN-1:0][31:0]         hi_tab;

    logic             hit;
    logic [WIN_W-1:0] win_idx;
    logic             grant, acc_viol, wr_viol;
    perm_e            code;
    err_kind_e        kind;

    logic [31:0]      err_addr;
    logic [SEL_W-1:0] err_sel;
    logic [CAU_W-1:0] cause;
    logic             locked;

    awg_cfg_regs #(.NUM_WIN(NUM_WIN), .NUM_CH(NUM_CH), .NUM_REMAP(NUM_REMAP)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .idx     (reg_idx),
        .wr_data (reg_wdata),
        .rd_data (cfg_rdata),
        .base_hi (base_hi),
        .mask_hi (mask_hi),
        .tgt     (tgt),
        .attr    (attr),
        .win_en  (win_en),
        .prot    (prot),
        .remap   (remap)
    );

    awg_window_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr_hi (req_addr[31:16]),
        .base_hi (base_hi),
        .mask_hi (mask_hi),
        .win_en  (win_en),
        .hit     (hit),
        .win_idx (win_idx)
    );

    assign code = perm_e'(prot[req_chan][2*win_idx +: 2]);

    awg_perm_check u_perm (
        .hit      (hit),
        .code     (code),
        .is_write (req_write),
        .grant    (grant),
        .acc_viol (acc_viol),
        .wr_viol  (wr_viol)
    );

    // Only the low windows own a remap register; the rest send a zero upper half.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_hi
        if (w < NUM_REMAP) begin : g_map
            assign hi_tab[w] = remap[w];
        end else begin : g_zero
            assign hi_tab[w] = '0;
        end
    end

    always_comb begin
        if (!hit)          kind = KIND_MISS;
        else if (acc_viol) kind = KIND_ACCESS;
        else if (wr_viol)  kind = KIND_WRITE;
        else               kind = KIND_NONE;
    end

    awg_err_log #(.NUM_CH(NUM_CH)) u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (req_valid && (kind != KIND_NONE)),
        .ev_kind     (kind),
        .ev_chan     (req_chan),
        .ev_addr     (req_addr),
        .release_req (reg_wr && (reg_idx == IDX_W'(REG_ERRSEL))),
        .cause_wr    (reg_wr && (reg_idx == IDX_W'(REG_CAUSE))),
        .cause_clr   (reg_wdata[CAU_W-1:0]),
        .err_addr    (err_addr),
        .err_sel     (err_sel),
        .cause       (cause),
        .locked      (locked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid    <= 1'b0;
            rsp_grant    <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_acc_viol <= 1'b0;
            rsp_wr_viol  <= 1'b0;
            rsp_win      <= '0;
            rsp_target   <= '0;
            rsp_attr     <= '0;
            rsp_addr     <= '0;
        end else begin
            rsp_valid    <= 1'b1;
            rsp_grant    <= grant;
            rsp_miss     <= !hit;
            rsp_acc_viol <= acc_viol;
            rsp_wr_viol  <= wr_viol;
            rsp_win      <= hit ? win_idx : '0;
            rsp_target   <= hit ? tgt[win_idx] : '0;
            rsp_attr     <= hit ? attr[win_idx] : '0;
            rsp_addr     <= {(hit ? hi_tab[win_idx] : 32'h0), req_addr};
        end
    end

    always_comb begin
        if (reg_idx == IDX_W'(REG_CAUSE))        reg_rdata = 32'(cause);
        else if (reg_idx == IDX_W'(REG_ERRADDR)) reg_rdata = err_addr;
        else if (reg_idx == IDX_W'(REG_ERRSEL))  reg_rdata = {locked, 31'(err_sel)};
        else                                     reg_rdata = cfg_rdata;
    end

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_grant, rsp_miss, rsp_acc_viol, rsp_wr_viol}) == 1));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_grant || rsp_miss || rsp_acc_viol || rsp_wr_viol));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_target == '0 && rsp_attr == '0 && rsp_addr[63:32] == '0));

    assert_remap_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && int'(rsp_win) >= NUM_REMAP) |-> (rsp_addr[63:32] == '0));

    assert_addr_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_addr[31:0] == $past(req_addr)));

endmodule

// File: tb/addr_window_guard_test.sv
`timescale 1ns/1ps
module addr_window_guard_test;

    localparam int NW = 8, NC = 4, NR = 4;
    localparam logic [4:0] I_BASE = 0, I_SIZE = 8, I_EN = 16, I_PROT = 20,
                           I_REMAP = 24, I_CAUSE = 28, I_EADDR = 29, I_ESEL = 30;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, reg_wr, req_valid, req_write;
    logic [4:0]  reg_idx;
    logic [31:0] reg_wdata, reg_rdata, req_addr;
    logic [1:0]  req_chan;
    logic        rsp_valid, rsp_grant, rsp_miss, rsp_acc_viol, rsp_wr_viol;
    logic [2:0]  rsp_win;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;
    logic [63:0] rsp_addr;

    addr_window_guard uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_chan(req_chan), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_miss(rsp_miss),
        .rsp_acc_viol(rsp_acc_viol), .rsp_wr_viol(rsp_wr_viol), .rsp_win(rsp_win),
        .rsp_target(rsp_target), .rsp_attr(rsp_attr), .rsp_addr(rsp_addr)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    logic [15:0] m_base [NW];
    logic [15:0] m_mask [NW];
    logic [3:0]  m_tgt  [NW];
    logic [7:0]  m_attr [NW];
    logic [7:0]  m_en;
    logic [15:0] m_prot [NC];
    logic [31:0] m_remap[NR];
    logic [31:0] m_cause, m_eaddr;
    logic [4:0]  m_esel;
    bit          m_lock;

    typedef struct packed {
        logic       ok, miss, acc, wrv;
        logic [2:0] win;
        logic [3:0] tgt;
        logic [7:0] attr;
        logic [31:0] hi;
    } exp_t;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic void model_write(logic [4:0] idx, logic [31:0] d);
        for (int w = 0; w < NW; w++) begin
            if (idx == 5'(I_BASE + w)) begin m_base[w] = d[31:16]; m_attr[w] = d[15:8]; m_tgt[w] = d[3:0]; end
            if (idx == 5'(I_SIZE + w)) m_mask[w] = d[31:16];
        end
        if (idx == I_EN) m_en = d[7:0];
        for (int c = 0; c < NC; c++) if (idx == 5'(I_PROT + c)) m_prot[c] = d[15:0];
        for (int r = 0; r < NR; r++) if (idx == 5'(I_REMAP + r)) m_remap[r] = d;
        if (idx == I_CAUSE) m_cause = m_cause & ~d;
        if (idx == I_ESEL)  m_lock = 0;
    endfunction

    function automatic exp_t predict(logic [31:0] a, logic wr, logic [1:0] ch);
        exp_t e = '0;
        int  hitw = -1;
        logic [1:0] code;
        for (int w = NW - 1; w >= 0; w--)
            if (m_en[w] && ((a[31:16] & ~m_mask[w]) == m_base[w])) hitw = w;
        if (hitw < 0) begin
            e.miss = 1;
            return e;
        end
        e.win  = 3'(hitw);
        e.tgt  = m_tgt[hitw];
        e.attr = m_attr[hitw];
        e.hi   = (hitw < NR) ? m_remap[hitw] : 32'h0;
        code   = m_prot[ch][2*hitw +: 2];
        if (code == 2'd3)      e.ok = 1;
        else if (code == 2'd1) begin if (wr) e.wrv = 1; else e.ok = 1; end
        else                   e.acc = 1;
        return e;
    endfunction

    task automatic wr_reg(logic [4:0] idx, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        model_write(idx, d);
    endtask

    task automatic rd_check(string req, logic [4:0] idx, logic [31:0] exp);
        @(negedge clk);
        reg_idx = idx;
        #1;
        check(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic do_req(string req, logic [31:0] a, logic wr, logic [1:0] ch);
        exp_t e;
        logic [2:0] kind;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr; req_chan = ch;
        e = predict(a, wr, ch);
        @(posedge clk);
        #1;
        check(req, {43'b0, rsp_valid, rsp_grant, rsp_miss, rsp_acc_viol, rsp_wr_viol, rsp_win, rsp_target, rsp_attr},
                   {43'b0, 1'b1, e.ok, e.miss, e.acc, e.wrv, e.win, e.tgt, e.attr});
        check(req, rsp_addr, {e.hi, a});
        kind = e.miss ? 3'd1 : e.acc ? 3'd2 : e.wrv ? 3'd3 : 3'd0;
        if (kind != 0) begin
            m_cause[8*ch + kind] = 1'b1;
            if (!m_lock) begin m_lock = 1; m_eaddr = a; m_esel = {ch, kind}; end
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic check_log(string req);
        rd_check(req, I_ESEL, {m_lock, 26'b0, m_esel});
        rd_check(req, I_EADDR, m_eaddr);
        rd_check(req, I_CAUSE, m_cause);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 0; reg_wr = 0; reg_idx = 0; reg_wdata = 0;
        req_valid = 0; req_write = 0; req_chan = 0; req_addr = 0;
        for (int w = 0; w < NW; w++) begin m_base[w] = 0; m_mask[w] = 0; m_tgt[w] = 0; m_attr[w] = 0; end
        for (int c = 0; c < NC; c++) m_prot[c] = 0;
        for (int r = 0; r < NR; r++) m_remap[r] = 0;
        m_en = 0; m_cause = 0; m_eaddr = 0; m_esel = 0; m_lock = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd_check("R1 enable", I_EN, 32'h0);
        rd_check("R1 base3", I_BASE + 5'd3, 32'h0);
        rd_check("R1 errsel", I_ESEL, 32'h0);
        rd_check("R1 cause", I_CAUSE, 32'h0);

        // R2: field packing on readback
        wr_reg(I_BASE, 32'hABCD_5A3F);
        rd_check("R2 base packing", I_BASE, 32'hABCD_5A0F);
        wr_reg(I_SIZE, 32'h1234_FFFF);
        rd_check("R2 size packing", I_SIZE, 32'h1234_0000);
        wr_reg(I_PROT, 32'hFFFF_FFFF);
        rd_check("R2 prot width", I_PROT, 32'h0000_FFFF);
        wr_reg(I_EN, 32'hFFFF_FF01);
        rd_check("R2 enable width", I_EN, 32'h0000_0001);
        wr_reg(I_REMAP + 5'd3, 32'hCAFE_F00D);
        rd_check("R2 remap3", I_REMAP + 5'd3, 32'hCAFE_F00D);

        // Directed configuration
        wr_reg(I_BASE + 5'd0, 32'h1000_A505); wr_reg(I_SIZE + 5'd0, 32'h00FF_0000);
        wr_reg(I_BASE + 5'd1, 32'h2000_1101); wr_reg(I_SIZE + 5'd1, 32'h000F_0000);
        wr_reg(I_BASE + 5'd2, 32'h2000_2202); wr_reg(I_SIZE + 5'd2, 32'h00FF_0000);
        wr_reg(I_BASE + 5'd5, 32'h3000_6606); wr_reg(I_SIZE + 5'd5, 32'h0000_0000);
        wr_reg(I_REMAP + 5'd0, 32'h0000_0007);
        wr_reg(I_REMAP + 5'd1, 32'hDEAD_0001);
        for (int c = 0; c < NC; c++) wr_reg(I_PROT + 5'(c), 32'h0000_FFFF);
        wr_reg(I_EN, 32'h0000_0027);

        do_req("R3 R5 inside window0", 32'h10AB_CDEF, 0, 0);
        do_req("R3 upper edge window0", 32'h10FF_FFFF, 0, 0);
        do_req("R3 R7 just past window0", 32'h1100_0000, 0, 0);
        do_req("R4 overlap lowest wins", 32'h2005_1234, 1, 2);
        do_req("R4 only wider window", 32'h2010_0000, 0, 2);
        do_req("R6 window5 no remap", 32'h3000_0010, 1, 3);

        // R10: first error (the miss) captured and locked
        rd_check("R10 errsel after first error", I_ESEL, 32'h8000_0001);
        rd_check("R10 erraddr after first error", I_EADDR, 32'h1100_0000);

        wr_reg(I_EN, 32'h0000_0026);
        do_req("R7 disabled window misses", 32'h10AB_CDEF, 0, 0);
        wr_reg(I_EN, 32'h0000_0027);

        // R8: per-channel codes: w0=0, w1=1, w2=2, w5=3 on channel 1
        wr_reg(I_PROT + 5'd1, 32'h0000_0C24);
        do_req("R8 code0 read blocked", 32'h1000_0000, 0, 1);
        do_req("R8 code1 read granted", 32'h2001_0000, 0, 1);
        do_req("R8 code1 write blocked", 32'h2001_0000, 1, 1);
        do_req("R8 code2 reserved blocked", 32'h2020_0000, 0, 1);
        do_req("R8 code3 write granted", 32'h3000_0000, 1, 1);
        do_req("R8 other channel unaffected", 32'h1000_0000, 1, 0);

        // R11: later errors did not move the log
        check_log("R11 R12 log held");

        // R12: write-1-to-clear
        wr_reg(I_CAUSE, 32'h0000_0402);
        rd_check("R12 cause after clear", I_CAUSE, m_cause);

        // R11: release keeps values, next error captured
        wr_reg(I_ESEL, 32'h0);
        rd_check("R11 released keeps select", I_ESEL, 32'h0000_0001);
        do_req("R10 miss channel3", 32'h7777_0000, 1, 3);
        rd_check("R10 recapture select", I_ESEL, 32'h8000_0019);
        rd_check("R10 recapture address", I_EADDR, 32'h7777_0000);

        // R13: idle cycle with a missing address is ignored
        @(negedge clk);
        req_valid = 0; req_addr = 32'hFFFF_FFFF; req_chan = 2;
        @(posedge clk);
        #1;
        check("R13 no response when idle", 64'(rsp_valid), 64'd0);
        check_log("R13 log unchanged when idle");

        // Random configuration and traffic
        for (int round = 0; round < 8; round++) begin
            for (int w = 0; w < NW; w++) begin
                logic [15:0] mk, bs;
                mk = 16'((1 << ($urandom % 7)) - 1);
                bs = 16'($urandom % 256) & ~mk;
                wr_reg(I_BASE + 5'(w), {bs, 8'($urandom), 4'h0, 4'($urandom)});
                wr_reg(I_SIZE + 5'(w), {mk, 16'h0});
            end
            for (int c = 0; c < NC; c++) wr_reg(I_PROT + 5'(c), 32'($urandom % 65536));
            for (int r = 0; r < NR; r++) wr_reg(I_REMAP + 5'(r), $urandom);
            wr_reg(I_EN, 32'($urandom % 256));
            for (int i = 0; i < 50; i++) begin
                do_req("R3 R4 R5 R6 R8 R9 random", {8'h00, 8'($urandom), 16'($urandom)},
                       1'($urandom), 2'($urandom));
                if (i % 10 == 9) check_log("R10 R11 R12 random log");
                if ($urandom % 16 == 0) wr_reg(I_ESEL, 32'h0);
                if ($urandom % 16 == 0) wr_reg(I_CAUSE, $urandom);
            end
        end

        finish_run();
    end

endmodule